// File: doc/BRIEF.md
# External Bus Address Decoder with Converter Port

This block is the glue logic on the external bus of an 8-bit microcontroller. It watches a 16-bit address and three active-low strobes: code fetch, data read and data write. From these it derives chip enables for a 32 KB program ROM and a 32 KB data RAM. It also derives read and write strobes for a 256-byte I/O page at the very top of memory. That page takes precedence over RAM, so only 0x8000 to 0xFEFF of the RAM can be reached. The I/O strobes are split again by address bit 0 into two input-port strobes and two output-port strobes.

A byte-wide analog-to-digital converter hangs off those ports. Reading input port 0 turns on the converter's three-state output. Writing output port 1 launches a fixed-length active-low start pulse. The converter's short active-low completion pulse is synchronised and edge-detected into a sticky "sample ready" flag, which software polls at bit 1 of input port 1. The flag clears when software reads the data port or starts a new conversion. A new completion edge wins over a clear that lands in the same clock.

The address decode is purely combinational. The start pulse and the flag are clocked by the system clock with a synchronous active-high reset.

Top module: `mcu_bus_glue`

## Requirements
- R1: `rom_sel_n` is low exactly when addr[15] is 0 and either `psen_n` or `rd_n` is low; a write alone never selects ROM.
- R2: `ram_sel_n` is low exactly when addr is in 0x8000..0xFEFF and any of `psen_n`, `rd_n`, `wr_n` is low.
- R3: For addr[15:8] = 0xFF, `io_rd_n` follows `rd_n` and `io_wr_n` follows `wr_n`, RAM stays deselected, and a code fetch there enables nothing.
- R4: In the I/O page, addr[0] = 0 selects port 0 and addr[0] = 1 selects port 1: `pin0_n`/`pin1_n` go low on I/O reads, and `pout0_n`/`pout1_n` go low on I/O writes.
- R5: At most one of ROM, RAM and I/O is enabled in any cycle, and all enables and port strobes are high when all three strobes are high.
- R6: `conv_oe_n` is low exactly when `pin0_n` is low.
- R7: A high-to-low transition of the port-1 write strobe, seen at a clock edge, drives `conv_start_n` low for exactly START_CLKS (4) clocks, starting at that edge.
- R8: The converter completion pulse (`conv_done_n` low) sets `sample_ready` at the third rising clock edge after it falls. `port1_data` always equals {6'b0, sample_ready, 1'b0}.
- R9: `sample_ready` clears at the clock edge where a port-0 read is active, or where a port-1 write edge is seen. A completion edge in that same clock keeps it set.
- R10: After reset, `sample_ready` is 0 and `conv_start_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| psen_n | input | 1 | Code fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| conv_done_n | input | 1 | Converter completion pulse, active low |
| rom_sel_n | output | 1 | ROM enable, active low |
| ram_sel_n | output | 1 | RAM enable, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| pin0_n | output | 1 | Input port 0 strobe |
| pin1_n | output | 1 | Input port 1 strobe |
| pout0_n | output | 1 | Output port 0 strobe |
| pout1_n | output | 1 | Output port 1 strobe |
| conv_oe_n | output | 1 | Converter output enable, active low |
| conv_start_n | output | 1 | Converter start pulse, active low |
| sample_ready | output | 1 | Sticky sample-ready flag |
| port1_data | output | 8 | Status byte read on input port 1 |

## Verification
The assertions assume that the bus master drives at most one strobe at a time and holds the address steady while a strobe is low. They also assume that a completion pulse stays low across at least two clock edges, so the synchroniser sees it. The bench changes inputs only on the falling clock edge and never overlaps strobes in its clocked tests. It holds each completion pulse for several clocks and waits for the start pulse to finish before it issues another write. The address sweep does visit overlapping strobe combinations, but only to check the combinational decode.

// File: rtl/mcu_bus_glue_pkg.sv
package mcu_bus_glue_pkg;
    localparam int ADDR_W     = 16;
    localparam int PAGE_W     = 8;
    localparam int START_CLKS = 4;
    localparam int SYNC_DEPTH = 2;
    localparam logic [PAGE_W-1:0] IO_PAGE = '1;

    typedef struct packed {
        logic psen;
        logic rd;
        logic wr;
    } strobe_t;

    typedef struct packed {
        logic rom;
        logic ram;
        logic io_rd;
        logic io_wr;
    } sel_t;

    typedef struct packed {
        logic in0;
        logic in1;
        logic out0;
        logic out1;
    } port_t;

    function automatic logic in_io_page(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: PAGE_W] == IO_PAGE;
    endfunction
endpackage

// File: rtl/space_decoder.sv
module space_decoder
    import mcu_bus_glue_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  strobe_t           act,
    output sel_t              sel
);
    logic io_hit;
    logic upper_half;

    always_comb begin
        io_hit     = in_io_page(addr);
        upper_half = addr[ADDR_W-1];
        sel.rom    = !upper_half && (act.psen || act.rd);
        sel.ram    = upper_half && !io_hit && (act.psen || act.rd || act.wr);
        sel.io_rd  = io_hit && act.rd;
        sel.io_wr  = io_hit && act.wr;
    end
endmodule

// File: rtl/port_splitter.sv
module port_splitter
    import mcu_bus_glue_pkg::*;
(
    input  logic  port_bit,
    input  sel_t  sel,
    output port_t ports
);
    always_comb begin
        ports.in0  = sel.io_rd && !port_bit;
        ports.in1  = sel.io_rd &&  port_bit;
        ports.out0 = sel.io_wr && !port_bit;
        ports.out1 = sel.io_wr &&  port_bit;
    end
endmodule

// File: rtl/conv_link.sv
module conv_link
    import mcu_bus_glue_pkg::*;
#(
    parameter int PULSE_CLKS = START_CLKS,
    parameter int SYNC_N     = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic data_read,
    input  logic done_n,
    output logic start_n,
    output logic ready
);
    localparam int CNT_W = $clog2(PULSE_CLKS + 1);

    logic             req_q;
    logic             start_edge;
    logic [CNT_W-1:0] pulse_cnt;
    logic [SYNC_N-1:0] sync_q;
    logic             done_prev;
    logic             done_fall;

    assign start_edge = start_req && !req_q;
    assign done_fall  = done_prev && !sync_q[SYNC_N-1];
    assign start_n    = (pulse_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            pulse_cnt <= '0;
        end else begin
            req_q <= start_req;
            if (start_edge)
                pulse_cnt <= CNT_W'(PULSE_CLKS);
            else if (pulse_cnt != '0)
                pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[g] <= 1'b1;
                else if (g == 0)
                    sync_q[g] <= done_n;
                else
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            done_prev <= 1'b1;
            ready     <= 1'b0;
        end else begin
            done_prev <= sync_q[SYNC_N-1];
            if (done_fall)
                ready <= 1'b1;
            else if (data_read || start_edge)
                ready <= 1'b0;
        end
    end
endmodule

// File: rtl/mcu_bus_glue.sv
module mcu_bus_glue
    import mcu_bus_glue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              psen_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              conv_done_n,
    output logic              rom_sel_n,
    output logic              ram_sel_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              pin0_n,
    output logic              pin1_n,
    output logic              pout0_n,
    output logic              pout1_n,
    output logic              conv_oe_n,
    output logic              conv_start_n,
    output logic              sample_ready,
    output logic [7:0]        port1_data
);
    strobe_t act;
    sel_t    sel;
    port_t   ports;

    assign act = '{psen: !psen_n, rd: !rd_n, wr: !wr_n};

    space_decoder u_dec (.addr(addr), .act(act), .sel(sel));

    port_splitter u_split (.port_bit(addr[0]), .sel(sel), .ports(ports));

    conv_link #(.PULSE_CLKS(START_CLKS), .SYNC_N(SYNC_DEPTH)) u_conv (
        .clk       (clk),
        .rst       (rst),
        .start_req (ports.out1),
        .data_read (ports.in0),
        .done_n    (conv_done_n),
        .start_n   (conv_start_n),
        .ready     (sample_ready)
    );

    assign rom_sel_n  = !sel.rom;
    assign ram_sel_n  = !sel.ram;
    assign io_rd_n    = !sel.io_rd;
    assign io_wr_n    = !sel.io_wr;
    assign pin0_n     = !ports.in0;
    assign pin1_n     = !ports.in1;
    assign pout0_n    = !ports.out0;
    assign pout1_n    = !ports.out1;
    assign conv_oe_n  = !ports.in0;
    assign port1_data = {6'b0, sample_ready, 1'b0};
endmodule

// File: rtl/mcu_bus_glue_checker.sv
module mcu_bus_glue_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        psen_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic        conv_done_n,
    input logic        rom_sel_n,
    input logic        ram_sel_n,
    input logic        io_rd_n,
    input logic        io_wr_n,
    input logic        pout1_n,
    input logic        conv_oe_n,
    input logic        conv_start_n,
    input logic        sample_ready
);
    assert_one_space_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!rom_sel_n, !ram_sel_n, !(io_rd_n && io_wr_n)}));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (psen_n && rd_n && wr_n) |-> (rom_sel_n && ram_sel_n && io_rd_n && io_wr_n));

    assert_no_rom_write_R1: assert property (@(posedge clk) disable iff (rst)
        (psen_n && rd_n) |-> rom_sel_n);

    assert_io_hides_ram_R3: assert property (@(posedge clk) disable iff (rst)
        (addr[15:8] == 8'hFF) |-> ram_sel_n);

    assert_oe_on_port0_read_R6: assert property (@(posedge clk) disable iff (rst)
        !conv_oe_n |-> (!rd_n && addr[15:8] == 8'hFF && !addr[0]));

    assert_start_follows_write_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pout1_n) |=> !conv_start_n);

    assert_ready_from_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_ready) |-> !$past(conv_done_n, 2));
endmodule

bind mcu_bus_glue mcu_bus_glue_checker u_chk (
    .clk(clk), .rst(rst), .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .conv_done_n(conv_done_n), .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .pout1_n(pout1_n), .conv_oe_n(conv_oe_n),
    .conv_start_n(conv_start_n), .sample_ready(sample_ready)
);

// File: tb/mcu_bus_glue_test.sv
`timescale 1ns/1ps
module mcu_bus_glue_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, conv_done_n = 1'b1;
    logic        rom_sel_n, ram_sel_n, io_rd_n, io_wr_n;
    logic        pin0_n, pin1_n, pout0_n, pout1_n, conv_oe_n, conv_start_n, sample_ready;
    logic [7:0]  port1_data;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    mcu_bus_glue uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (addr=%h)", req, act, exp, addr);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        psen_n = 1; rd_n = 1; wr_n = 1;
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R10: reset state
        chk("R10 ready", sample_ready, 0);
        chk("R10 start", conv_start_n, 1);

        // R1..R6 exhaustive sweep over page, port bit and strobe combos
        for (int pg = 0; pg < 256; pg++) begin
            for (int lo = 0; lo < 2; lo++) begin
                for (int s = 0; s < 8; s++) begin
                    logic ps, rd, wr, up, io;
                    logic e_rom, e_ram, e_ird, e_iwr;
                    addr = 16'(pg * 256 + lo);
                    psen_n = !s[2]; rd_n = !s[1]; wr_n = !s[0];
                    #1;
                    ps = s[2]; rd = s[1]; wr = s[0];
                    up = pg >= 128; io = pg == 255;
                    e_rom = !up && (ps || rd);
                    e_ram = up && !io && (ps || rd || wr);
                    e_ird = io && rd;
                    e_iwr = io && wr;
                    chk("R1 rom", rom_sel_n, !e_rom);
                    chk("R2 ram", ram_sel_n, !e_ram);
                    chk("R3 iord", io_rd_n, !e_ird);
                    chk("R3 iowr", io_wr_n, !e_iwr);
                    chk("R4 ports", {pin0_n, pin1_n, pout0_n, pout1_n},
                        {!(e_ird && lo == 0), !(e_ird && lo == 1),
                         !(e_iwr && lo == 0), !(e_iwr && lo == 1)});
                    chk("R6 oe", conv_oe_n, !(e_ird && lo == 0));
                    if (s == 0)
                        chk("R5 idle", {rom_sel_n, ram_sel_n, io_rd_n, io_wr_n}, 4'hF);
                    if (s == 1 || s == 2 || s == 4)
                        chk("R5 onehot", 32'($countones({!rom_sel_n, !ram_sel_n,
                            !(io_rd_n && io_wr_n)})) <= 1, 1);
                    tick();
                end
            end
        end
        idle();
        rst = 1; tick(); tick(); rst = 0;
        chk("R10 ready after sweep reset", sample_ready, 0);

        // R7: start pulse of 4 clocks
        addr = 16'hFFFF; wr_n = 0;
        tick(); // edge seen at the posedge before this negedge
        for (int k = 0; k < 4; k++) begin
            chk("R7 start low", conv_start_n, 0);
            if (k == 0) wr_n = 1;
            tick();
        end
        chk("R7 start ends", conv_start_n, 1);

        // R8: completion sets flag on third edge
        conv_done_n = 0;
        tick(); chk("R8 not yet 1", sample_ready, 0);
        tick(); chk("R8 not yet 2", sample_ready, 0);
        tick(); chk("R8 set", sample_ready, 1);
        repeat (3) tick();
        conv_done_n = 1;
        chk("R8 sticky", sample_ready, 1);
        addr = 16'hFF01; rd_n = 0; #1;
        chk("R8 status byte", port1_data, 8'h02);
        tick(); rd_n = 1;
        chk("R8 read of port1 keeps flag", sample_ready, 1);

        // R9: data read clears
        addr = 16'hFF00; rd_n = 0;
        tick(); rd_n = 1;
        chk("R9 clear by read", sample_ready, 0);
        chk("R8 status byte clear", port1_data, 8'h00);
        repeat (3) tick();

        // R9: start write clears
        conv_done_n = 0; repeat (3) tick(); conv_done_n = 1;
        chk("R9 set before start", sample_ready, 1);
        addr = 16'hFFFF; wr_n = 0;
        tick(); wr_n = 1;
        chk("R9 clear by start", sample_ready, 0);
        repeat (6) tick();

        // R9: set wins over simultaneous read clear
        conv_done_n = 0;
        tick(); tick();
        addr = 16'hFF00; rd_n = 0;
        tick(); rd_n = 1;
        chk("R9 set priority", sample_ready, 1);
        tick();
        chk("R9 flag held after", sample_ready, 1);
        conv_done_n = 1;
        repeat (4) tick();

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule